// File: doc/BRIEF.md
# T1/E1 Multiframe Sync and Signaling Latch

This block keeps the bit, timeslot and frame position of one T1 or E1 serial TDM port, one bit per port clock. It handles three multiframe lengths: T1 with 12 frames, T1 with 24 frames, and E1 with 16 frames. A T1 frame is 193 clocks long: one framing bit followed by 24 eight-bit timeslots. An E1 frame is 256 clocks long: 32 eight-bit timeslots. At 1.544 or 2.048 MHz, either frame lasts 125 us.

The sync line can be used in either direction. In output direction, the block marks the first bit of each frame, or of each multiframe, with a one-clock pulse. In input direction, it samples an external boundary pulse on the port clock. A pulse at the expected position leaves the counters as they are. A pulse anywhere else pulls the counters onto it and sets a sticky misalignment flag.

Channel-associated signaling (four bits per timeslot) is collected from a serial input into a shadow store during a multiframe. The shadow store is moved to the output store when the next multiframe starts. The serialised output therefore changes only at multiframe boundaries.

Top module: `tdm_mf_sync`

## Requirements
- R1: With reset (`rst_n` low, synchronous) released, the block stands at bit 0 of frame 0, so `sync_o`=1. In the same state `misalign`=0, `sig_o`=0, and `sync_oe` equals the inverse of `sync_dir_in`.
- R2: `mode_sel` picks the format: 0 = T1 with 12 frames per multiframe, 1 = T1 with 24 frames, 2 or 3 = E1 with 16 frames. A frame lasts 193 clocks for T1 and 256 clocks for E1.
- R3: `sync_o` is high for exactly one clock, at bit 0 of every frame when `sync_is_mf`=0, and at bit 0 of frame 0 only when `sync_is_mf`=1. This holds in both sync directions.
- R4: With `sync_dir_in`=1, a `sync_i` pulse at the expected mark leaves the counters and the flag alone. A pulse anywhere else makes that clock bit 0. The frame count is also set to 0 when `sync_is_mf`=1. `misalign` is set and stays high until reset.
- R5: With `sync_dir_in`=0, `sync_i` has no effect on the counters or on `misalign`.
- R6: Timeslot layout within a frame:
  - T1: bit 0 is the framing bit, and timeslot t occupies bits 1+8t to 8+8t.
  - E1: timeslot t occupies bits 8t to 8t+7.
  - Offsets 4 to 7 within each timeslot carry signaling bits 0 to 3. `sig_i` is sampled there into the shadow store, and the latest sample of a multiframe wins.
  - `sig_i` at all other positions is ignored.
- R7: `sig_o` presents, at the same positions, the signaling captured during the previous multiframe, and drives 0 at every other position. The presented values change only when a multiframe starts.
- R8: When `mode_sel` differs from the active format, the next clock is bit 0 of frame 0 in the new format, and the shadow store is cleared. The multiframe that follows therefore presents all-zero signaling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Format select (0 T1/12, 1 T1/24, 2-3 E1/16) |
| sync_dir_in | input | 1 | 1: sync line is an input, 0: output |
| sync_is_mf | input | 1 | 1: sync marks multiframes, 0: frames |
| sync_i | input | 1 | External boundary pulse |
| sync_o | output | 1 | Internal boundary pulse |
| sync_oe | output | 1 | Drive enable for the sync line |
| sig_i | input | 1 | Serial signaling input |
| sig_o | output | 1 | Serial signaling output, updated per multiframe |
| misalign | output | 1 | Sticky flag for an off-position sync input pulse |

## Verification
A wrong bit or frame count shows first on `sync_o`. A pulse comes one or more clocks early or late, or is missing, within one frame (about 256 clocks) in frame-mark mode, or within one multiframe in multiframe mode. A wrong timeslot mapping or a wrong copy instant in the signaling stores shows on `sig_o` one multiframe later, as wrong or shifting bits. A realignment that lands on the wrong position, or an unwanted realignment, shows as a `sync_o` pulse that is off by a fixed offset from then on. A spurious realignment also shows at once on `misalign`.

// File: rtl/tdm_mf_sync.sv
module tdm_mf_sync (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       sync_dir_in,
  input  logic       sync_is_mf,
  input  logic       sync_i,
  output logic       sync_o,
  output logic       sync_oe,
  input  logic       sig_i,
  output logic       sig_o,
  output logic       misalign
);
  localparam int BITW  = 8;
  localparam int FRMW  = 5;
  localparam int NSLOT = 32;
  localparam int NCAS  = 4;
  localparam logic [BITW-1:0] T1_LAST = BITW'(192);
  localparam logic [BITW-1:0] E1_LAST = BITW'(255);

  logic [1:0]                 mode_q;
  logic [BITW-1:0]            bit_q;
  logic [FRMW-1:0]            frm_q;
  logic [NSLOT-1:0][NCAS-1:0] shadow_q, cas_q;
  logic                       misalign_q;

  wire             is_t1    = ~mode_q[1];
  wire [BITW-1:0]  bit_last = is_t1 ? T1_LAST : E1_LAST;
  wire [FRMW-1:0]  frm_last = (mode_q == 2'd0) ? FRMW'(11) :
                              (mode_q == 2'd1) ? FRMW'(23) : FRMW'(15);
  wire             mode_chg = mode_sel != mode_q;
  wire             on_mark  = (bit_q == '0) && (!sync_is_mf || frm_q == '0);
  wire             realign  = sync_dir_in && sync_i && !on_mark;
  wire [BITW-1:0]  eff_bit  = realign ? '0 : bit_q;
  wire [FRMW-1:0]  eff_frm  = (realign && sync_is_mf) ? '0 : frm_q;
  wire             mf_start = (eff_bit == '0) && (eff_frm == '0);
  wire [BITW-1:0]  dpos     = is_t1 ? eff_bit - BITW'(1) : eff_bit;
  wire             cas_pos  = dpos[2] && !(is_t1 && eff_bit == '0);
  wire [4:0]       ts       = dpos[7:3];
  wire [1:0]       nb       = dpos[1:0];

  assign sync_o   = (eff_bit == '0) && (!sync_is_mf || eff_frm == '0);
  assign sync_oe  = ~sync_dir_in;
  assign sig_o    = cas_pos && cas_q[ts][nb];
  assign misalign = misalign_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= mode_sel;
      bit_q      <= '0;
      frm_q      <= '0;
      shadow_q   <= '0;
      cas_q      <= '0;
      misalign_q <= 1'b0;
    end else if (mode_chg) begin
      mode_q   <= mode_sel;
      bit_q    <= '0;
      frm_q    <= '0;
      shadow_q <= '0;
    end else begin
      if (realign)  misalign_q <= 1'b1;
      if (mf_start) cas_q <= shadow_q;
      if (cas_pos)  shadow_q[ts][nb] <= sig_i;
      if (eff_bit == bit_last) begin
        bit_q <= '0;
        frm_q <= (eff_frm == frm_last) ? '0 : FRMW'(eff_frm + FRMW'(1));
      end else begin
        bit_q <= BITW'(eff_bit + BITW'(1));
        frm_q <= eff_frm;
      end
    end
  end

  a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q <= bit_last) && (frm_q <= frm_last));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && !mode_chg) |=> (!sync_o || (sync_dir_in && sync_i)));

  a_r4_realign_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (realign && !mode_chg) |=> (bit_q == BITW'(1)) && misalign);

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> misalign);

  a_r5_out_dir_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_dir_in && !misalign) |=> !misalign);

  a_r7_cas_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_start |=> $stable(cas_q));

  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (bit_q == '0) && (frm_q == '0) && (shadow_q == '0));
endmodule

// File: tb/sim_tdm_mf_sync.sv
module sim_tdm_mf_sync;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic sync_dir_in = 1'b0, sync_is_mf = 1'b1, sync_i = 1'b0, sig_i = 1'b0;
  logic sync_o, sync_oe, sig_o, misalign;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  tdm_mf_sync u0 (.clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .sync_dir_in(sync_dir_in), .sync_is_mf(sync_is_mf), .sync_i(sync_i),
    .sync_o(sync_o), .sync_oe(sync_oe), .sig_i(sig_i), .sig_o(sig_o),
    .misalign(misalign));

  function automatic int flen(int m); return (m < 2) ? 193 : 256; endfunction
  function automatic int mfl(int m); return (m == 0) ? 12 : (m == 1) ? 24 : 16; endfunction

  function automatic int cas_ix(int m, int b);
    int d;
    if (m < 2 && b == 0) return -1;
    d = (m < 2) ? b - 1 : b;
    if (d % 8 < 4) return -1;
    return (d / 8) * 4 + (d % 8) - 4;
  endfunction

  function automatic bit pat(int k, int ix);
    int v = (ix / 4) * 5 + k * 3 + 1;
    return 1'((v >> (ix % 4)) & 1);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(int m, bit din, bit mfs);
    @(negedge clk);
    rst_n = 1'b0; mode_sel = 2'(m); sync_dir_in = din; sync_is_mf = mfs;
    sync_i = 1'b0; sig_i = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1; #1;
    chk(sync_o === 1'b1, "R1 sync_o after reset", int'(sync_o), 1);
    chk(misalign === 1'b0, "R1 misalign after reset", int'(misalign), 0);
    chk(sig_o === 1'b0, "R1 sig_o after reset", int'(sig_o), 0);
    chk(sync_oe === !din, "R1 sync_oe", int'(sync_oe), int'(!din));
  endtask

  // expk: -1 all zero, -2 all ones, else pattern index; drive 1 = all ones
  task automatic run_mf(int m, int k, int drive, int expk, string tag);
    int fl = flen(m), nf = mfl(m), bad_s = 0, bad_g = 0, as1 = 0, es1 = 0, ag = 0, eg = 0;
    for (int p = 0; p < fl * nf; p++) begin
      int b = p % fl;
      int f = p / fl;
      int ix = cas_ix(m, b);
      bit es, eg1;
      if (ix < 0 || drive == 1) sig_i = 1'b1;
      else sig_i = (f == nf - 1) ? pat(k, ix) : !pat(k, ix);
      #1;
      es = (b == 0) && (!sync_is_mf || f == 0);
      eg1 = (ix < 0 || expk == -1) ? 1'b0 : (expk == -2) ? 1'b1 : pat(expk, ix);
      if (sync_o !== es && bad_s == 0) begin as1 = int'(sync_o); es1 = int'(es); end
      if (sync_o !== es) bad_s++;
      if (sig_o !== eg1 && bad_g == 0) begin ag = int'(sig_o); eg = int'(eg1); end
      if (sig_o !== eg1) bad_g++;
      @(negedge clk);
    end
    chk(bad_s == 0, {tag, " R2 R3 sync_o pulse position"}, as1, es1);
    chk(bad_g == 0, {tag, " R6 R7 sig_o content"}, ag, eg);
  endtask

  task automatic test_formats();
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 2; s++) begin
        do_reset(m, 1'b0, 1'(s));
        run_mf(m, 0, 0, -1, "fmt mf0");
        run_mf(m, 1, 0, 0, "fmt mf1");
        run_mf(m, 2, 0, 1, "fmt mf2");
      end
  endtask

  task automatic scan_sync(int n, string tag);
    int bad = 0, at = 0;
    for (int p = 1; p < n; p++) begin
      if (sync_o !== 1'b0) begin bad++; at = p; end
      @(negedge clk); #1;
    end
    chk(bad == 0, {tag, " no early pulse"}, at, 0);
    chk(sync_o === 1'b1, {tag, " pulse at mark"}, int'(sync_o), 1);
  endtask

  task automatic test_input_align();
    do_reset(0, 1'b1, 1'b1);
    sync_i = 1'b1; @(negedge clk); sync_i = 1'b0; #1;
    chk(misalign === 1'b0, "R4 expected pulse no flag", int'(misalign), 0);
    scan_sync(2316, "R4 aligned");
    sync_i = 1'b1; @(negedge clk); sync_i = 1'b0; #1;
    chk(misalign === 1'b0, "R4 second expected pulse no flag", int'(misalign), 0);
    for (int p = 1; p < 100; p++) @(negedge clk);
    sync_i = 1'b1; #1;
    chk(sync_o === 1'b1, "R4 off-mark pulse becomes mark", int'(sync_o), 1);
    @(negedge clk); sync_i = 1'b0; #1;
    chk(misalign === 1'b1, "R4 flag set", int'(misalign), 1);
    scan_sync(2316, "R4 realigned multiframe");
    chk(misalign === 1'b1, "R4 flag sticky", int'(misalign), 1);
    do_reset(2, 1'b1, 1'b0);
    for (int p = 0; p < 50; p++) @(negedge clk);
    sync_i = 1'b1; @(negedge clk); sync_i = 1'b0; #1;
    scan_sync(256, "R4 frame-mark realign");
  endtask

  task automatic test_output_ignore();
    do_reset(0, 1'b0, 1'b1);
    for (int p = 0; p < 100; p++) @(negedge clk);
    sync_i = 1'b1; #1;
    chk(sync_o === 1'b0, "R5 sync_i ignored same clock", int'(sync_o), 0);
    @(negedge clk); sync_i = 1'b0; #1;
    chk(misalign === 1'b0, "R5 no flag", int'(misalign), 0);
    for (int p = 101; p < 2316; p++) @(negedge clk);
    #1;
    chk(sync_o === 1'b1, "R5 counters unmoved", int'(sync_o), 1);
  endtask

  task automatic test_mode_change();
    do_reset(0, 1'b0, 1'b1);
    run_mf(0, 0, 0, -1, "R8 pre");
    for (int p = 0; p < 50; p++) @(negedge clk);
    mode_sel = 2'd2;
    @(negedge clk); #1;
    chk(sync_o === 1'b1, "R8 restart at mark", int'(sync_o), 1);
    run_mf(2, 0, 1, -1, "R8 cleared shadow");
    run_mf(2, 0, 1, -2, "R8 new format capture");
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    test_formats();
    test_input_align();
    test_output_ignore();
    test_mode_change();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule